// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts

A memory-mapped general-purpose I/O controller that serves a parameterized number of 32-pin banks (two by default). Each pin has a direction bit and an output value. Software changes output values only through write-only set and clear strobes, so it never needs a read-modify-write sequence on the output state. The pin inputs pass through a two-flop synchronizer. After that, each pin can raise an event on a rising edge, a falling edge, both edges, or an active level whose polarity is selectable.

Events latch into a sticky interrupt-source register. Software clears it by writing ones to it. The single interrupt line is the OR, across all banks, of the pending bits whose mask bit is set. A second sticky register, the wake source, collects events only from pins whose wake-mask bit is set, and it also clears by writing ones.

The register bus is single-cycle. A write commits on the clock edge where `we_i` is high, and read data is combinational from the address. Each register type is an array of 32-bit words, one word per bank.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, `pin_o`, `pin_oe_o` and `irq_o` are zero, and every readable configuration, mask and status word reads zero.
- R2: Pin n is bit n%32 of the word at a type's base plus 4*(n/32). The bases are:
  - 0x004 synchronized level (read-only)
  - 0x01C direction
  - 0x034 set strobe
  - 0x04C clear strobe
  - 0x064 rising enable
  - 0x07C falling enable
  - 0x0AC interrupt mask
  - 0x0C4 interrupt source
  - 0x300 detect type
  - 0x318 level polarity
  - 0x400 wake mask
  - 0x418 wake source
- R3: Writing ones to the set strobe drives those pins' `pin_o` bits high on the next cycle. Zero bits leave their pins unchanged, and the strobe word reads zero.
- R4: Writing ones to the clear strobe drives those `pin_o` bits low. Zero bits leave their pins unchanged, and the strobe word reads zero.
- R5: A direction bit of 1 drives the matching `pin_oe_o` bit high (output), and 0 makes the pin an input. The direction word reads back what was written.
- R6: The level word returns the pin input after the two-flop synchronizer, two clock edges after `pin_i` changes.
- R7: With detect type 0 (edge), a source bit sets on a rising edge when the rising enable is 1 and on a falling edge when the falling enable is 1. Both enables may be set together. The bit appears three edges after the `pin_i` change.
- R8: With detect type 1 (level), the source bit sets while the synchronized pin is high if polarity is 0, or while it is low if polarity is 1.
- R9: Writing 1 to a source bit clears it, and writing 0 has no effect. While a level event is still active, the clear does not take hold. An event in the same cycle as a clear leaves the bit set.
- R10: `irq_o` is high exactly when some pending source bit has its mask bit set, in any bank.
- R11: A wake-source bit sets only on an event of a pin whose wake-mask bit is 1. It clears when software writes 1 to it.
- R12: Reads of unmapped addresses return zero, and writes to them or to the level word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write enable, commits at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| pin_i | input | 64 | Pin input levels |
| pin_o | output | 64 | Pin output values |
| pin_oe_o | output | 64 | Pin output enables |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Register effects are due one edge after the write: output and enable changes, cleared status bits, and configuration readback. A change on `pin_i` reaches the level word after two edges and the source, wake and `irq_o` outputs after three edges. The bench drives every input at a falling edge and counts the matching number of falling edges before it samples. The same-cycle case holds the clear write across exactly the third edge after a pin change, so the clear and the edge event meet in one cycle.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    RK_NONE  = 4'd0,
    RK_LEVEL = 4'd1,
    RK_DIR   = 4'd2,
    RK_SET   = 4'd3,
    RK_CLR   = 4'd4,
    RK_RISE  = 4'd5,
    RK_FALL  = 4'd6,
    RK_MASK  = 4'd7,
    RK_SRC   = 4'd8,
    RK_TYPE  = 4'd9,
    RK_POL   = 4'd10,
    RK_WMASK = 4'd11,
    RK_WSRC  = 4'd12
  } reg_kind_e;

  localparam int NUM_KINDS = 12;

  function automatic logic [ADDR_W-1:0] base_of(reg_kind_e k);
    case (k)
      RK_LEVEL: base_of = 12'h004;
      RK_DIR:   base_of = 12'h01C;
      RK_SET:   base_of = 12'h034;
      RK_CLR:   base_of = 12'h04C;
      RK_RISE:  base_of = 12'h064;
      RK_FALL:  base_of = 12'h07C;
      RK_MASK:  base_of = 12'h0AC;
      RK_SRC:   base_of = 12'h0C4;
      RK_TYPE:  base_of = 12'h300;
      RK_POL:   base_of = 12'h318;
      RK_WMASK: base_of = 12'h400;
      RK_WSRC:  base_of = 12'h418;
      default:  base_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic         wr_i,
  input  reg_kind_e    kind_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic         irq_o
);
  logic [W-1:0] out_q, dir_q, ren_q, fen_q, msk_q, src_q;
  logic [W-1:0] typ_q, pol_q, wmsk_q, wsrc_q, prev_q;
  logic [W-1:0] rise, fall, evt;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  // per pin: level type compares against polarity, edge type gated by enables
  always_comb begin
    for (int i = 0; i < W; i++)
      evt[i] = typ_q[i] ? (sync_i[i] ^ pol_q[i])
                        : ((rise[i] & ren_q[i]) | (fall[i] & fen_q[i]));
  end

  function automatic logic [W-1:0] upd(logic [W-1:0] cur, reg_kind_e k);
    return (wr_i && kind_i == k) ? wdata_i : cur;
  endfunction

  function automatic logic [W-1:0] w1c(reg_kind_e k);
    return (wr_i && kind_i == k) ? wdata_i : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      msk_q  <= '0;
      src_q  <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      wmsk_q <= '0;
      wsrc_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sync_i;
      out_q  <= (out_q | w1c(RK_SET)) & ~w1c(RK_CLR);
      dir_q  <= upd(dir_q, RK_DIR);
      ren_q  <= upd(ren_q, RK_RISE);
      fen_q  <= upd(fen_q, RK_FALL);
      msk_q  <= upd(msk_q, RK_MASK);
      typ_q  <= upd(typ_q, RK_TYPE);
      pol_q  <= upd(pol_q, RK_POL);
      wmsk_q <= upd(wmsk_q, RK_WMASK);
      // event wins over a same-cycle clear
      src_q  <= (src_q & ~w1c(RK_SRC)) | evt;
      wsrc_q <= (wsrc_q & ~w1c(RK_WSRC)) | (evt & wmsk_q);
    end
  end

  always_comb begin
    case (kind_i)
      RK_LEVEL: rdata_o = sync_i;
      RK_DIR:   rdata_o = dir_q;
      RK_RISE:  rdata_o = ren_q;
      RK_FALL:  rdata_o = fen_q;
      RK_MASK:  rdata_o = msk_q;
      RK_SRC:   rdata_o = src_q;
      RK_TYPE:  rdata_o = typ_q;
      RK_POL:   rdata_o = pol_q;
      RK_WMASK: rdata_o = wmsk_q;
      RK_WSRC:  rdata_o = wsrc_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_o = out_q;
  assign oe_o  = dir_q;
  assign irq_o = |(src_q & msk_q);

  a_r3_set_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == RK_SET) |=> ((pin_o & $past(wdata_i)) == $past(wdata_i)));

  a_r4_clr_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == RK_CLR) |=> ((pin_o & $past(wdata_i)) == '0));

  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == RK_SRC) |=> ((src_q & $past(wdata_i) & ~$past(evt)) == '0));

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((src_q & $past(evt)) == $past(evt)));

  a_r11_wake_only_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wsrc_q & ~$past(wsrc_q) & ~$past(wmsk_q)) == '0));

  a_r5_oe_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && kind_i == RK_DIR) |=> $stable(oe_o));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_BANKS = 2,  // register windows allow up to 6
  parameter int BANK_W    = 32,
  localparam int NPINS    = NUM_BANKS * BANK_W,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  reg_kind_e         hit_kind;
  logic [BSEL_W-1:0] hit_bank;
  logic [NPINS-1:0]  pin_sync;
  logic [BANK_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  always_comb begin
    hit_kind = RK_NONE;
    hit_bank = '0;
    for (int k = 1; k <= NUM_KINDS; k++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (addr_i == base_of(reg_kind_e'(k)) + ADDR_W'(4 * b)) begin
          hit_kind = reg_kind_e'(k);
          hit_bank = BSEL_W'(b);
        end
      end
    end
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = (hit_bank == BSEL_W'(b)) && (hit_kind != RK_NONE);

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (pin_sync[b*BANK_W +: BANK_W]),
      .wr_i   (we_i && bank_sel),
      .kind_i (bank_sel ? hit_kind : RK_NONE),
      .wdata_i(wdata_i),
      .rdata_o(bank_rd[b]),
      .pin_o  (pin_o[b*BANK_W +: BANK_W]),
      .oe_o   (pin_oe_o[b*BANK_W +: BANK_W]),
      .irq_o  (bank_irq[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      rdata_o |= bank_rd[b];
  end

  assign irq_o = |bank_irq;

  a_r12_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_kind == RK_NONE) |-> (rdata_o == '0));
endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  localparam logic [11:0] A_LVL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034,
    A_CLR = 12'h04C, A_RIS = 12'h064, A_FAL = 12'h07C, A_MSK = 12'h0AC,
    A_SRC = 12'h0C4, A_TYP = 12'h300, A_POL = 12'h318, A_WMK = 12'h400,
    A_WSR = 12'h418;

  // {addr, write data, expected readback}
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {A_DIR,        32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {A_DIR + 12'h4, 32'h8000_0001, 32'h8000_0001},
    {A_SET,        32'h0000_FFFF, 32'h0000_0000},
    {A_CLR + 12'h4, 32'hFFFF_0000, 32'h0000_0000},
    {A_RIS + 12'h4, 32'h1234_5678, 32'h1234_5678},
    {A_FAL,        32'h0F00_00F0, 32'h0F00_00F0},
    {A_POL,        32'h5555_AAAA, 32'h5555_AAAA},
    {A_WMK + 12'h4, 32'hC000_0003, 32'hC000_0003},
    {12'h00C,      32'hFFFF_FFFF, 32'h0000_0000},
    {A_LVL,        32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    settle(2);
    rst_ni = 1'b1;
    settle(1);
  endtask

  initial begin
    logic [31:0] r;
    settle(2);
    rst_ni = 1'b1;
    settle(1);

    // R1 reset state
    chk("R1 pin_o", pin_out, 64'h0);
    chk("R1 pin_oe", pin_oe, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
    rd(A_SRC, r); chk("R1 src", {32'h0, r}, 64'h0);
    rd(A_DIR + 12'h4, r); chk("R1 dir1", {32'h0, r}, 64'h0);

    // R2/R5/R3/R4/R12 readback table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], r);
      chk("R2 table readback", {32'h0, r}, {32'h0, VEC[i][31:0]});
    end
    chk("R5 oe from dir", pin_oe, 64'h8000_0001_A5A5_0F0F);
    chk("R12 level write ignored, R3 set effect", pin_out, 64'h0000_0000_0000_FFFF);
    do_reset();
    chk("R1 reset again", pin_oe, 64'h0);

    // R3/R4 set and clear strobes
    wr(A_SET, 32'h0000_00F0);
    chk("R3 set", pin_out, 64'h0000_0000_0000_00F0);
    wr(A_CLR, 32'h0000_0030);
    chk("R4 clear", pin_out, 64'h0000_0000_0000_00C0);
    wr(A_SET + 12'h4, 32'h8000_0000);
    chk("R3 set bank1", pin_out, 64'h8000_0000_0000_00C0);
    wr(A_CLR, 32'h0);
    chk("R4 zero clear no effect", pin_out, 64'h8000_0000_0000_00C0);

    // R6 level synchronizer latency
    @(negedge clk); pin_in[63:32] = 32'hDEAD_BEEF;
    settle(1); rd(A_LVL + 12'h4, r);
    chk("R6 level not yet", {32'h0, r}, 64'h0);
    settle(1); rd(A_LVL + 12'h4, r);
    chk("R6 level after two edges", {32'h0, r}, 64'hDEAD_BEEF);
    pin_in[63:32] = '0;
    settle(3);

    // R7 edges: pin 3 rising only, pin 5 both edges
    wr(A_RIS, 32'h0000_0028);
    wr(A_FAL, 32'h0000_0020);
    wr(A_MSK, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1; pin_in[5] = 1'b1;
    settle(2);
    chk("R7 irq not yet", {63'h0, irq}, 64'h0);
    settle(1);
    chk("R10 irq on masked pending", {63'h0, irq}, 64'h1);
    rd(A_SRC, r); chk("R7 rising events", {32'h0, r}, 64'h28);
    wr(A_SRC, 32'h0000_0028);
    rd(A_SRC, r); chk("R9 w1c", {32'h0, r}, 64'h0);
    chk("R10 irq drops", {63'h0, irq}, 64'h0);
    @(negedge clk); pin_in[3] = 1'b0; pin_in[5] = 1'b0;
    settle(3);
    rd(A_SRC, r); chk("R7 falling only where enabled", {32'h0, r}, 64'h20);
    chk("R10 unmasked pending no irq", {63'h0, irq}, 64'h0);
    wr(A_SRC, 32'h0000_0020);

    // R9 event and clear in the same cycle: pin 7 rising
    wr(A_RIS, 32'h0000_0080);
    @(negedge clk); pin_in[7] = 1'b1;
    settle(1);
    @(negedge clk); addr = A_SRC; wdata = 32'h0000_0080; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(A_SRC, r); chk("R9 event wins over clear", {32'h0, r}, 64'h80);
    wr(A_SRC, 32'h0000_0080);
    rd(A_SRC, r); chk("R9 later clear", {32'h0, r}, 64'h0);

    // R8 level type, active low, bank1 bit 8 (pin 40)
    wr(A_POL + 12'h4, 32'h0000_0100);
    wr(A_TYP + 12'h4, 32'h0000_0100);
    settle(1);
    rd(A_SRC + 12'h4, r); chk("R8 active-low level", {32'h0, r}, 64'h100);
    wr(A_SRC + 12'h4, 32'h0000_0100);
    rd(A_SRC + 12'h4, r); chk("R9 clear blocked while active", {32'h0, r}, 64'h100);
    @(negedge clk); pin_in[40] = 1'b1;
    settle(3);
    wr(A_SRC + 12'h4, 32'h0000_0100);
    rd(A_SRC + 12'h4, r); chk("R8 inactive then cleared", {32'h0, r}, 64'h0);
    // active-high polarity on same pin
    wr(A_POL + 12'h4, 32'h0);
    settle(1);
    wr(A_MSK + 12'h4, 32'h0000_0100);
    chk("R10 irq from bank1", {63'h0, irq}, 64'h1);
    rd(A_SRC + 12'h4, r); chk("R8 active-high level", {32'h0, r}, 64'h100);
    wr(A_TYP + 12'h4, 32'h0);
    wr(A_SRC + 12'h4, 32'h0000_0100);
    chk("R10 irq cleared", {63'h0, irq}, 64'h0);

    // R11 wake: pins 10 and 11 rising, only 10 wake-masked
    wr(A_RIS, 32'h0000_0C00);
    wr(A_WMK, 32'h0000_0400);
    @(negedge clk); pin_in[10] = 1'b1; pin_in[11] = 1'b1;
    settle(3);
    rd(A_WSR, r); chk("R11 wake masked pin only", {32'h0, r}, 64'h400);
    rd(A_SRC, r); chk("R7 both pins pending", {32'h0, r}, 64'hC00);
    wr(A_WSR, 32'h0000_0400);
    rd(A_WSR, r); chk("R11 wake w1c", {32'h0, r}, 64'h0);
    rd(A_SRC, r); chk("R11 wake clear leaves source", {32'h0, r}, 64'hC00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule